// File: doc/BRIEF.md
# Cascaded Second-Order-Section Recursive Filter

This block realises a recursive (IIR) transfer function of order `ORDER` as a chain of second-order sections placed one after another. A fixed gain constant scales the input before the first section. Each section sees only the output of the section before it. When the order is odd, the last section is first order. All sections share one storage width for their delayed samples and one rounding and saturation policy, so the whole chain is quantised the same way at every stage. Splitting a high-order recursion into short sections keeps each pole pair's sensitivity to coefficient rounding small.

The gain, the coefficient sets and the quantisation options are elaboration-time parameters. The block takes one signed sample per enabled clock and returns one filtered sample per enabled clock. A synchronous reset clears every delayed sample. A clock enable freezes the whole chain.

Top module: `iir_cascade`

## Requirements
- R1: The block holds `(ORDER+1)/2` sections in series after the gain stage. Coefficient j of section k sits in `SEC_COEFS[(6*k+j)*COEF_W +: COEF_W]`, with j = 0..5 meaning a0, a1, a2, b0, b1, b2 in that order.
- R2: A sample taken on an enabled clock edge first affects `yout` after the (NSEC+1)-th enabled edge, counting the edge that took it. With the defaults (NSEC = 2), a lone impulse of 16384 gives 0 after two edges and 1536 after three.
- R3: The gain stage registers `sat(round(xin * GAIN_K) >>> GAIN_FRAC)`, where `GAIN_K` is signed and has `GAIN_FRAC` fractional bits.
- R4: Each section computes `a0*x[n] + a1*x[n-1] + a2*x[n-2] - b1*y[n-1] - b2*y[n-2]`. The coefficients have `COEF_FRAC` fractional bits, and b0 is ignored because it is taken as 1.
- R5: When `ROUND_EN` is set, every scaled result has 2^(F-1) added before the arithmetic right shift by F. When `SAT_EN` is set, every result is then clamped to the signed `DATA_W` range; otherwise it wraps.
- R6: When `ORDER` is odd, the last section ignores its a2 and b2 values and behaves as a first-order section.
- R7: While `rst` is high, every clock edge clears all stored samples, and `yout` is 0 after that edge.
- R8: While `en` is low, no stored sample changes, `yout` holds and `xin` is ignored.
- R9: With all stored samples at zero, a zero input keeps every section's output at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Clock, rising edge |
| rst  | input  | 1 | Synchronous reset, active high |
| en   | input  | 1 | Clock enable, active high |
| xin  | input  | DATA_W | Signed input sample |
| yout | output | DATA_W | Signed filtered sample, registered |

## Verification
The gain stage and each section add one register each. A sample driven before enabled edge t therefore reaches `yout` after edge t+NSEC, which is three edges with the defaults. The bench runs an integer model of the chain that advances only on enabled edges and has the same register count. It compares `yout` against the model half a clock after every edge. Directed checks fix the impulse arrival edge, the frozen output during disabled cycles, and the zero output one edge after reset.

// File: rtl/iir_pkg.sv
package iir_pkg;

    // Position of each coefficient inside one section's slot
    typedef enum int {
        CI_A0 = 0,
        CI_A1 = 1,
        CI_A2 = 2,
        CI_B0 = 3,
        CI_B1 = 4,
        CI_B2 = 5
    } coef_idx_e;

    localparam int COEFS_PER_SEC = 6;

    // Scale down by 2^frac, optionally rounding half up
    function automatic logic signed [63:0] requant(input logic signed [63:0] acc,
                                                   input int frac,
                                                   input bit rnd);
        logic signed [63:0] t;
        t = acc;
        if (rnd && frac > 0) t = t + (64'sd1 <<< (frac - 1));
        return t >>> frac;
    endfunction

    // Clamp or wrap to a signed range of the given width
    function automatic logic signed [63:0] limit(input logic signed [63:0] v,
                                                 input int width,
                                                 input bit sat);
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        hi = (64'sd1 <<< (width - 1)) - 64'sd1;
        lo = -hi - 64'sd1;
        if (sat) begin
            if (v > hi) return hi;
            if (v < lo) return lo;
            return v;
        end
        return (v <<< (64 - width)) >>> (64 - width);
    endfunction

endpackage

// File: rtl/iir_gain_stage.sv
module iir_gain_stage #(
    parameter int                         DATA_W   = 16,
    parameter int                         COEF_W   = 16,
    parameter int                         FRAC     = 14,
    parameter logic signed [COEF_W-1:0]   K        = 16'sd16384,
    parameter bit                         ROUND_EN = 1'b1,
    parameter bit                         SAT_EN   = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic signed [DATA_W-1:0]  x_i,
    output logic signed [DATA_W-1:0]  g_o
);
    logic signed [DATA_W-1:0] g_d, g_q;
    logic signed [63:0]       prod, q;

    always_comb begin
        prod = 64'(K) * 64'(x_i);
        q    = iir_pkg::limit(iir_pkg::requant(prod, FRAC, ROUND_EN), DATA_W, SAT_EN);
        g_d  = g_q;
        if (rst)     g_d = '0;
        else if (en) g_d = q[DATA_W-1:0];
    end

    always_ff @(posedge clk) g_q <= g_d;

    assign g_o = g_q;

    // R7: reset clears the scaled sample
    a_r7_gain_clear: assert property (@(posedge clk) rst |=> g_o == '0);
    // R3: a zero input scales to zero
    a_r3_gain_zero: assert property (@(posedge clk) disable iff (rst)
        (en && x_i == '0) |=> g_o == '0);
endmodule

// File: rtl/iir_sos.sv
module iir_sos #(
    parameter int                         DATA_W      = 16,
    parameter int                         COEF_W      = 16,
    parameter int                         FRAC        = 14,
    parameter bit                         ROUND_EN    = 1'b1,
    parameter bit                         SAT_EN      = 1'b1,
    parameter bit                         FIRST_ORDER = 1'b0,
    parameter logic signed [COEF_W-1:0]   A0 = '0,
    parameter logic signed [COEF_W-1:0]   A1 = '0,
    parameter logic signed [COEF_W-1:0]   A2 = '0,
    parameter logic signed [COEF_W-1:0]   B1 = '0,
    parameter logic signed [COEF_W-1:0]   B2 = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic signed [DATA_W-1:0]  x_i,
    output logic signed [DATA_W-1:0]  y_o
);
    // A first-order variant drops the second tap on both paths
    localparam logic signed [COEF_W-1:0] A2E = FIRST_ORDER ? '0 : A2;
    localparam logic signed [COEF_W-1:0] B2E = FIRST_ORDER ? '0 : B2;

    typedef struct packed {
        logic signed [DATA_W-1:0] x1;
        logic signed [DATA_W-1:0] x2;
        logic signed [DATA_W-1:0] y1;
        logic signed [DATA_W-1:0] y2;
    } sos_st_t;

    sos_st_t            st_d, st_q;
    logic signed [63:0] acc, q;

    always_comb begin
        acc = 64'(A0)  * 64'(x_i)
            + 64'(A1)  * 64'(st_q.x1)
            + 64'(A2E) * 64'(st_q.x2)
            - 64'(B1)  * 64'(st_q.y1)
            - 64'(B2E) * 64'(st_q.y2);
        q    = iir_pkg::limit(iir_pkg::requant(acc, FRAC, ROUND_EN), DATA_W, SAT_EN);
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (en) begin
            st_d.x2 = st_q.x1;
            st_d.x1 = x_i;
            st_d.y2 = st_q.y1;
            st_d.y1 = q[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign y_o = st_q.y1;

    // R8: disabled cycles leave every delayed sample untouched
    a_r8_sec_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st_q));
    // R9: zero state with zero input stays silent
    a_r9_zero_rest: assert property (@(posedge clk) disable iff (rst)
        (en && x_i == '0 && st_q == '0) |=> y_o == '0);
    // R7: reset empties the delay line
    a_r7_sec_clear: assert property (@(posedge clk) rst |=> st_q == '0);
endmodule

// File: rtl/iir_cascade.sv
module iir_cascade #(
    parameter int                       ORDER     = 3,
    parameter int                       DATA_W    = 16,
    parameter int                       COEF_W    = 16,
    parameter int                       COEF_FRAC = 14,
    parameter int                       GAIN_FRAC = 14,
    parameter logic signed [COEF_W-1:0] GAIN_K    = 16'sd12288,
    parameter bit                       ROUND_EN  = 1'b1,
    parameter bit                       SAT_EN    = 1'b1,
    parameter logic [((ORDER+1)/2)*6*COEF_W-1:0] SEC_COEFS = {
        16'sd2000, -16'sd4096, 16'sd16384, 16'sd1000, 16'sd8192, 16'sd8192,
        16'sd4096, -16'sd8192, 16'sd16384, 16'sd4096, 16'sd8192, 16'sd4096
    }
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic signed [DATA_W-1:0]  xin,
    output logic signed [DATA_W-1:0]  yout
);
    localparam int NSEC = (ORDER + 1) / 2;
    localparam int CPS  = iir_pkg::COEFS_PER_SEC;
    localparam bit ODD  = (ORDER % 2) == 1;

    // link[0] is the scaled input, link[k+1] the output of section k
    logic signed [DATA_W-1:0] link [NSEC+1];

    iir_gain_stage #(
        .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(GAIN_FRAC), .K(GAIN_K),
        .ROUND_EN(ROUND_EN), .SAT_EN(SAT_EN)
    ) u_gain (
        .clk(clk), .rst(rst), .en(en), .x_i(xin), .g_o(link[0])
    );

    for (genvar k = 0; k < NSEC; k++) begin : g_sec
        localparam int BASE = k * CPS;
        iir_sos #(
            .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(COEF_FRAC),
            .ROUND_EN(ROUND_EN), .SAT_EN(SAT_EN),
            .FIRST_ORDER(ODD && (k == NSEC - 1)),
            .A0(SEC_COEFS[(BASE + iir_pkg::CI_A0)*COEF_W +: COEF_W]),
            .A1(SEC_COEFS[(BASE + iir_pkg::CI_A1)*COEF_W +: COEF_W]),
            .A2(SEC_COEFS[(BASE + iir_pkg::CI_A2)*COEF_W +: COEF_W]),
            .B1(SEC_COEFS[(BASE + iir_pkg::CI_B1)*COEF_W +: COEF_W]),
            .B2(SEC_COEFS[(BASE + iir_pkg::CI_B2)*COEF_W +: COEF_W])
        ) u_sec (
            .clk(clk), .rst(rst), .en(en), .x_i(link[k]), .y_o(link[k+1])
        );
    end

    assign yout = link[NSEC];

    // R7: output is zero one edge after reset
    a_r7_out_clear: assert property (@(posedge clk) rst |=> yout == '0);
    // R8: output frozen while disabled
    a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(yout));
endmodule

// File: tb/sim_iir_cascade.sv
module sim_iir_cascade;
    localparam int DW = 16;
    localparam int CF = 14;
    localparam logic signed [15:0] K    = 16'sd12288;
    // section 0 (second order)
    localparam logic signed [15:0] S0A0 = 16'sd4096,  S0A1 = 16'sd8192, S0A2 = 16'sd4096;
    localparam logic signed [15:0] S0B0 = 16'sd16384, S0B1 = -16'sd8192, S0B2 = 16'sd4096;
    // section 1 (first order: its a2/b2 carry junk that must be ignored)
    localparam logic signed [15:0] S1A0 = 16'sd8192,  S1A1 = 16'sd8192, S1A2 = 16'sd1000;
    localparam logic signed [15:0] S1B0 = 16'sd16384, S1B1 = -16'sd4096, S1B2 = 16'sd2000;

    localparam int NV = 20;
    localparam int VX [NV] = '{1000, -2000, 5000, 12000, -16000, 0, 0, 300, 32767, -32768,
                               20000, 20000, -7, 7, 1, -1, 9000, -9000, 15000, 0};
    localparam bit VE [NV] = '{1, 1, 1, 1, 1, 0, 1, 1, 1, 1,
                               0, 1, 1, 1, 0, 1, 1, 1, 1, 1};

    logic clk = 1'b0;
    logic rst, en;
    logic signed [DW-1:0] xin, yout;
    int n_chk = 0, n_bad = 0;

    // model state
    longint mg, m0x1, m0x2, m0y1, m0y2, m1x1, m1y1;

    always #5 clk = ~clk;

    iir_cascade #(
        .ORDER(3), .DATA_W(DW), .COEF_W(16), .COEF_FRAC(CF), .GAIN_FRAC(CF), .GAIN_K(K),
        .ROUND_EN(1'b1), .SAT_EN(1'b1),
        .SEC_COEFS({S1B2, S1B1, S1B0, S1A2, S1A1, S1A0, S0B2, S0B1, S0B0, S0A2, S0A1, S0A0})
    ) u0 (.clk(clk), .rst(rst), .en(en), .xin(xin), .yout(yout));

    function automatic longint qz(longint acc);
        longint v;
        v = (acc + (64'sd1 <<< (CF - 1))) >>> CF;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    task automatic model_step(input longint x, input bit r, input bit e);
        longint ng, n0, n1;
        if (r) begin
            mg = 0; m0x1 = 0; m0x2 = 0; m0y1 = 0; m0y2 = 0; m1x1 = 0; m1y1 = 0;
        end else if (e) begin
            ng = qz(longint'(K) * x);
            n0 = qz(longint'(S0A0) * mg + longint'(S0A1) * m0x1 + longint'(S0A2) * m0x2
                    - longint'(S0B1) * m0y1 - longint'(S0B2) * m0y2);
            n1 = qz(longint'(S1A0) * m0y1 + longint'(S1A1) * m1x1 - longint'(S1B1) * m1y1);
            m1x1 = m0y1; m1y1 = n1;
            m0x2 = m0x1; m0x1 = mg; m0y2 = m0y1; m0y1 = n0;
            mg = ng;
        end
    endtask

    task automatic check(input longint act, input longint exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at negedge, clock once, return at the following negedge
    task automatic tick(input int x, input bit r, input bit e);
        xin = DW'(x); rst = r; en = e;
        model_step(longint'(x), r, e);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint held;
        rst = 1'b1; en = 1'b1; xin = '0;
        @(negedge clk);
        tick(0, 1'b1, 1'b1);
        tick(0, 1'b1, 1'b1);
        check(yout, 0, "R7 reset state");

        // R9: silence in, silence out
        for (int i = 0; i < 4; i++) begin
            tick(0, 1'b0, 1'b1);
            check(yout, 0, "R9 zero input");
        end

        // R2: impulse arrival edge
        tick(16384, 1'b0, 1'b1);
        tick(0, 1'b0, 1'b1);
        check(yout, 0, "R2 impulse not yet due");
        tick(0, 1'b0, 1'b1);
        check(yout, 1536, "R2 impulse first output");
        for (int i = 0; i < 6; i++) begin
            tick(0, 1'b0, 1'b1);
            check(yout, m1y1, "R2/R4 impulse tail");
        end

        // vector table: R1 R3 R4 R5 R6 and R8 via mixed enables
        for (int i = 0; i < NV; i++) begin
            tick(VX[i], 1'b0, VE[i]);
            check(yout, m1y1, "R1/R3/R4/R5/R6 vector");
        end

        // R8: held output during disabled cycles with moving input
        held = yout;
        for (int i = 0; i < 5; i++) begin
            tick(i * 7000 - 14000, 1'b0, 1'b0);
            check(yout, held, "R8 hold while disabled");
        end
        for (int i = 0; i < 4; i++) begin
            tick(3000, 1'b0, 1'b1);
            check(yout, m1y1, "R8 resume after hold");
        end

        // R5: saturation at both ends of the range
        for (int i = 0; i < 40; i++) tick(32767, 1'b0, 1'b1);
        check(yout, 32767, "R5 positive saturation");
        check(yout, m1y1, "R5 positive model");
        for (int i = 0; i < 40; i++) tick(-32768, 1'b0, 1'b1);
        check(yout, -32768, "R5 negative saturation");

        // R7: reset in the middle of activity
        tick(0, 1'b1, 1'b1);
        check(yout, 0, "R7 mid-run reset");
        tick(0, 1'b0, 1'b1);
        check(yout, 0, "R7 state emptied");

        // R6: step through the first-order tail after reset
        for (int i = 0; i < 8; i++) begin
            tick(8000, 1'b0, 1'b1);
            check(yout, m1y1, "R6 first-order step");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule